// File: doc/BRIEF.md
# USB Device Power Control Unit

This block owns the device-level power state of a USB function. Firmware reaches it through a small register bus with three registers: a power control register, an interrupt-enable register and an interrupt-flag register. The bus interface logic feeds it three level inputs: bus reset seen, suspend seen and resume seen. Each input passes through a configurable synchronizer. The unit then detects the first cycle of each condition.

When a bus reset begins, the unit emits a one-cycle set of clear strobes. These clear the device address, flush the endpoint FIFOs, clear the endpoint control/status registers and clear the index register. The same cycle presets the interrupt enables and updates the flags. The unit enters suspend when detection is enabled and suspend signaling appears. It leaves suspend on resume signaling, on a firmware remote wakeup, on a bus reset or on any reset.

The function enable is driven from an inhibit bit. This bit is set after power-on. Firmware can only clear it, and can bring it back only by commanding a self-reset of the function.

Top module: `usbpwr_ctl`

Register addresses: 0 = power control, 1 = interrupt enable, 2 = interrupt flags. Interrupt bit positions in registers 1 and 2: bit 0 = suspend, bit 1 = resume, bit 2 = bus reset. Power register bits: 0 = suspend-detect enable (read/write), 1 = suspend status (read-only), 2 = remote wakeup (read/write), 3 = bus reset in progress on read / self-reset command on write, 4 = inhibit.

## Requirements
- R1: After `rst`, the power register reads 0x10, the enable register reads 0x06, the flag register reads 0x00, `func_en` is 0 and all strobes are 0. Unused bits and unmapped addresses read 0.
- R2: A power-register write with bit 4 = 0 clears the inhibit and raises `func_en`. A later write with bit 4 = 1 leaves the inhibit at 0.
- R3: The strobe outputs `addr_clr`, `fifo_flush`, `csr_clr`, `idx_clr` and `ien_preset` are 1 for exactly one cycle. That cycle is EVT_STAGES+1 clock edges after `bus_rst_det` rises.
- R4: Power bit 3 reads 1 while the synchronized bus-reset input is high. It reads 0 once the input has fallen.
- R5: On a bus reset, enable bits 1 and 2 become 1 and enable bit 0 is kept. Flag bit 1 is cleared, flag bit 2 is set and flag bit 0 is kept.
- R6: A rise of `bus_susp_det` with power bit 0 = 1 sets `susp_state` and sets flag bit 0 if enable bit 0 is 1. With power bit 0 = 0 the rise changes neither.
- R7: While suspended, a rise of `bus_resm_det` clears `susp_state` and sets flag bit 1 if enable bit 1 is 1. When not suspended, a resume rise sets no flag. A bus reset also clears `susp_state`.
- R8: Writing power bit 2 = 1 drives `wake_drive` high and clears `susp_state`. The drive stays until firmware writes bit 2 = 0.
- R9: A power-register write with bit 3 = 1 returns all three registers to their R1 values, including the inhibit. On the following cycle it pulses the R3 strobes once.
- R10: Writing 1 to a flag bit clears it. Writing 0 to a flag bit leaves it unchanged.
- R11: The enable register stores bits 2:0 and reads 0 in its upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data of the addressed register |
| bus_rst_det | input | 1 | Bus reset signaling level |
| bus_susp_det | input | 1 | Bus suspend signaling level |
| bus_resm_det | input | 1 | Bus resume signaling level |
| addr_clr | output | 1 | Device address clear strobe |
| fifo_flush | output | 1 | Endpoint FIFO flush strobe |
| csr_clr | output | 1 | Endpoint control/status clear strobe |
| idx_clr | output | 1 | Index register clear strobe |
| ien_preset | output | 1 | Interrupt-enable preset strobe |
| irq_flags | output | 3 | Interrupt flags (suspend, resume, bus reset) |
| susp_state | output | 1 | Suspended |
| wake_drive | output | 1 | Drive remote-wakeup resume signaling |
| func_en | output | 1 | Function enabled (inhibit clear) |

## Verification
The bench builds the unit with EVT_STAGES = 3 and ADDR_W = 3. The deeper synchronizer makes the bench wait four edges for every event effect, which exposes any latency mistake in the rise detection. The wider address lets the bench reach unmapped locations and confirm that they read zero. All strobe, suspend-entry and flag timing checks are derived from that four-edge latency.

// File: rtl/usbpwr_pkg.sv
package usbpwr_pkg;
  // power register bit positions
  localparam int PWR_SUSEN = 0;
  localparam int PWR_SUSST = 1;
  localparam int PWR_WAKE  = 2;
  localparam int PWR_RSTF  = 3;
  localparam int PWR_INH   = 4;

  // event and interrupt indices (shared order)
  localparam int EV_SUSP = 0;
  localparam int EV_RESM = 1;
  localparam int EV_BRST = 2;
  localparam int NUM_EVT = 3;
  localparam int NUM_IRQ = 3;

  // register addresses
  localparam int RA_PWR  = 0;
  localparam int RA_IEN  = 1;
  localparam int RA_IFLG = 2;

  localparam logic [NUM_IRQ-1:0] IEN_DEFAULT = 3'b110;
endpackage

// File: rtl/usbpwr_evsync.sv
module usbpwr_evsync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
          always_ff @(posedge clk) begin
            if (rst) stage_q[g] <= '0;
            else     stage_q[g] <= din;
          end
        end else begin : g_next
          always_ff @(posedge clk) begin
            if (rst) stage_q[g] <= '0;
            else     stage_q[g] <= stage_q[g-1];
          end
        end
      end
      assign dout = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/usbpwr_pwrreg.sv
module usbpwr_pwrreg
  import usbpwr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               soft_rst,
  input  logic               wr_pwr,
  input  logic               wr_susen,
  input  logic               wr_wake,
  input  logic               wr_inh,
  input  logic [NUM_EVT-1:0] evt_lvl,
  output logic [NUM_EVT-1:0] evt_rise,
  output logic [DATA_W-1:0]  pwr_word,
  output logic               susen_q,
  output logic               susp_q,
  output logic               wake_q,
  output logic               inh_q,
  output logic               rstf_q,
  output logic               enter_susp,
  output logic               exit_resm,
  output logic               strobe_q
);
  logic [NUM_EVT-1:0] prev_q;
  logic               wake_nxt;
  logic               leave_susp;

  // edge memory survives a self-reset so an ongoing level is not re-seen
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= evt_lvl;
  end

  assign evt_rise   = evt_lvl & ~prev_q;
  assign wake_nxt   = wr_pwr ? wr_wake : wake_q;
  assign exit_resm  = evt_rise[EV_RESM] & susp_q;
  assign leave_susp = evt_rise[EV_BRST] | exit_resm | wake_nxt;
  assign enter_susp = evt_rise[EV_SUSP] & susen_q & ~susp_q
                    & ~evt_lvl[EV_BRST] & ~evt_lvl[EV_RESM] & ~wake_nxt;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      susen_q <= 1'b0;
      susp_q  <= 1'b0;
      wake_q  <= 1'b0;
      inh_q   <= 1'b1;
      rstf_q  <= 1'b0;
    end else begin
      rstf_q <= evt_lvl[EV_BRST];
      if (wr_pwr) begin
        susen_q <= wr_susen;
        wake_q  <= wr_wake;
        if (!wr_inh) inh_q <= 1'b0;
      end
      if (leave_susp)      susp_q <= 1'b0;
      else if (enter_susp) susp_q <= 1'b1;
    end
  end

  // one shared register feeds every clear strobe
  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= evt_rise[EV_BRST] | soft_rst;
  end

  always_comb begin
    pwr_word           = '0;
    pwr_word[PWR_SUSEN] = susen_q;
    pwr_word[PWR_SUSST] = susp_q;
    pwr_word[PWR_WAKE]  = wake_q;
    pwr_word[PWR_RSTF]  = rstf_q;
    pwr_word[PWR_INH]   = inh_q;
  end
endmodule

// File: rtl/usbpwr_irq.sv
module usbpwr_irq
  import usbpwr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_all,
  input  logic               brst_rise,
  input  logic               set_susp,
  input  logic               set_resm,
  input  logic               wr_ien,
  input  logic               wr_flg,
  input  logic [NUM_IRQ-1:0] wbits,
  output logic [NUM_IRQ-1:0] ien_q,
  output logic [NUM_IRQ-1:0] flg_q
);
  logic [NUM_IRQ-1:0] ien_nxt;
  logic [NUM_IRQ-1:0] flg_nxt;

  always_comb begin
    ien_nxt = ien_q;
    if (wr_ien) ien_nxt = wbits;
    if (brst_rise) begin
      ien_nxt[EV_RESM] = 1'b1;
      ien_nxt[EV_BRST] = 1'b1;
    end
  end

  always_comb begin
    flg_nxt = flg_q;
    if (wr_flg) flg_nxt = flg_nxt & ~wbits;
    if (set_susp && ien_q[EV_SUSP]) flg_nxt[EV_SUSP] = 1'b1;
    if (brst_rise) begin
      flg_nxt[EV_RESM] = 1'b0;
      flg_nxt[EV_BRST] = 1'b1;
    end else if (set_resm && ien_q[EV_RESM]) begin
      flg_nxt[EV_RESM] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_all) begin
      ien_q <= IEN_DEFAULT;
      flg_q <= '0;
    end else begin
      ien_q <= ien_nxt;
      flg_q <= flg_nxt;
    end
  end
endmodule

// File: rtl/usbpwr_ctl.sv
module usbpwr_ctl
  import usbpwr_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 8,
  parameter int EVT_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              bus_rst_det,
  input  logic              bus_susp_det,
  input  logic              bus_resm_det,
  output logic              addr_clr,
  output logic              fifo_flush,
  output logic              csr_clr,
  output logic              idx_clr,
  output logic              ien_preset,
  output logic [2:0]        irq_flags,
  output logic              susp_state,
  output logic              wake_drive,
  output logic              func_en
);
  localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(RA_PWR);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(RA_IEN);
  localparam logic [ADDR_W-1:0] A_IFLG = ADDR_W'(RA_IFLG);

  logic [NUM_EVT-1:0] evt_raw, evt_lvl, evt_rise;
  logic               wr_pwr, wr_ien, wr_flg, soft_rst;
  logic [DATA_W-1:0]  pwr_word;
  logic               susen_w, susp_w, wake_w, inh_w, rstf_w;
  logic               enter_susp, exit_resm, strobe_q;
  logic [NUM_IRQ-1:0] ien_w, flg_w;
  logic               unused_wbits;

  always_comb begin
    evt_raw          = '0;
    evt_raw[EV_SUSP] = bus_susp_det;
    evt_raw[EV_RESM] = bus_resm_det;
    evt_raw[EV_BRST] = bus_rst_det;
  end

  assign wr_pwr   = reg_wr && (reg_addr == A_PWR);
  assign wr_ien   = reg_wr && (reg_addr == A_IEN);
  assign wr_flg   = reg_wr && (reg_addr == A_IFLG);
  assign soft_rst = wr_pwr && reg_wdata[PWR_RSTF];
  assign unused_wbits = ^reg_wdata[DATA_W-1:PWR_INH+1];

  usbpwr_evsync #(.STAGES(EVT_STAGES), .WIDTH(NUM_EVT)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (evt_raw),
    .dout (evt_lvl)
  );

  usbpwr_pwrreg #(.DATA_W(DATA_W)) u_pwr (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .wr_pwr     (wr_pwr),
    .wr_susen   (reg_wdata[PWR_SUSEN]),
    .wr_wake    (reg_wdata[PWR_WAKE]),
    .wr_inh     (reg_wdata[PWR_INH]),
    .evt_lvl    (evt_lvl),
    .evt_rise   (evt_rise),
    .pwr_word   (pwr_word),
    .susen_q    (susen_w),
    .susp_q     (susp_w),
    .wake_q     (wake_w),
    .inh_q      (inh_w),
    .rstf_q     (rstf_w),
    .enter_susp (enter_susp),
    .exit_resm  (exit_resm),
    .strobe_q   (strobe_q)
  );

  usbpwr_irq u_irq (
    .clk       (clk),
    .rst_all   (rst || soft_rst),
    .brst_rise (evt_rise[EV_BRST]),
    .set_susp  (enter_susp),
    .set_resm  (exit_resm),
    .wr_ien    (wr_ien),
    .wr_flg    (wr_flg),
    .wbits     (reg_wdata[NUM_IRQ-1:0]),
    .ien_q     (ien_w),
    .flg_q     (flg_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        A_PWR:   reg_rdata <= pwr_word;
        A_IEN:   reg_rdata <= DATA_W'(ien_w);
        A_IFLG:  reg_rdata <= DATA_W'(flg_w);
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign addr_clr   = strobe_q;
  assign fifo_flush = strobe_q;
  assign csr_clr    = strobe_q;
  assign idx_clr    = strobe_q;
  assign ien_preset = strobe_q;
  assign irq_flags  = flg_w;
  assign susp_state = susp_w;
  assign wake_drive = wake_w;
  assign func_en    = ~inh_w;
endmodule

// File: rtl/usbpwr_ctl_chk.sv
module usbpwr_ctl_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              func_en,
  input logic              susp_state,
  input logic              wake_drive,
  input logic              addr_clr,
  input logic              susen_w,
  input logic              rstf_w
);
  logic self_rst;
  assign self_rst = reg_wr && (reg_addr == '0) && reg_wdata[3];

  // R2: once enabled, only a self-reset can disable
  a_r2_inhibit_sticky: assert property (@(posedge clk) disable iff (rst)
    (func_en && !self_rst) |=> func_en);

  // R9: self-reset restores defaults and pulses the clears
  a_r9_self_reset: assert property (@(posedge clk) disable iff (rst)
    self_rst |=> (!func_en && addr_clr && !susp_state && !wake_drive));

  // R8: remote wakeup and suspend never coexist
  a_r8_wake_not_suspended: assert property (@(posedge clk) disable iff (rst)
    wake_drive |-> !susp_state);

  // R6: entry into suspend needs detection enabled
  a_r6_entry_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(susp_state) |-> $past(susen_w));

  // R7: no suspend while a bus reset is seen
  a_r7_no_suspend_in_reset: assert property (@(posedge clk) disable iff (rst)
    rstf_w |-> !susp_state);
endmodule

bind usbpwr_ctl usbpwr_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .func_en    (func_en),
  .susp_state (susp_state),
  .wake_drive (wake_drive),
  .addr_clr   (addr_clr),
  .susen_w    (susen_w),
  .rstf_w     (rstf_w)
);

// File: tb/usbpwr_ctl_test.sv
module usbpwr_ctl_test;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 8;
  localparam int EVT_STAGES = 3;
  localparam int LAT        = EVT_STAGES + 1;
  localparam int NVEC       = 10;

  // {addr, write data, expected readback}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd0, 8'h11, 8'h11},  // R2 inhibit kept when bit 4 written 1
    {8'd0, 8'h01, 8'h01},  // R2 inhibit cleared
    {8'd0, 8'h11, 8'h01},  // R2 cannot be set again
    {8'd0, 8'hE1, 8'h01},  // R1 unused bits read 0
    {8'd1, 8'hFF, 8'h07},  // R11 upper enable bits read 0
    {8'd1, 8'h01, 8'h01},  // R11
    {8'd0, 8'h05, 8'h05},  // R8 wake bit stored
    {8'd0, 8'h01, 8'h01},  // R8 wake bit cleared
    {8'd2, 8'h07, 8'h00},  // R10 clearing empty flags
    {8'd1, 8'h06, 8'h06}   // R11
  };
  localparam int VEC_REQ [NVEC] = '{2, 2, 2, 1, 11, 11, 8, 8, 10, 11};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic              reg_wr = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              bus_rst_det = 1'b0, bus_susp_det = 1'b0, bus_resm_det = 1'b0;
  logic              addr_clr, fifo_flush, csr_clr, idx_clr, ien_preset;
  logic [2:0]        irq_flags;
  logic              susp_state, wake_drive, func_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  usbpwr_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EVT_STAGES(EVT_STAGES)) uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_rst_det(bus_rst_det), .bus_susp_det(bus_susp_det), .bus_resm_det(bus_resm_det),
    .addr_clr(addr_clr), .fifo_flush(fifo_flush), .csr_clr(csr_clr),
    .idx_clr(idx_clr), .ien_preset(ien_preset), .irq_flags(irq_flags),
    .susp_state(susp_state), .wake_drive(wake_drive), .func_en(func_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_addr  = ADDR_W'(a);
    reg_wdata = DATA_W'(d);
    reg_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input int e);
    reg_addr = ADDR_W'(a);
    @(posedge clk);
    @(negedge clk);
    chk(req, 32'(reg_rdata), 32'(e));
  endtask

  task automatic ev_wait();
    repeat (LAT) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (LAT + 1) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [4:0] strobes();
    return {addr_clr, fifo_flush, csr_clr, idx_clr, ien_preset};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 func_en", 32'(func_en), 0);
    chk("R1 strobes", 32'(strobes()), 0);
    chk("R1 susp_state", 32'(susp_state), 0);
    chk("R1 irq_flags", 32'(irq_flags), 0);
    rd_chk("R1 power reg", 0, 8'h10);
    rd_chk("R1 enable reg", 1, 8'h06);
    rd_chk("R1 flag reg", 2, 8'h00);
    rd_chk("R1 unmapped", 5, 8'h00);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(int'(VEC[i][23:16]), int'(VEC[i][15:8]));
      rd_chk($sformatf("R%0d vector %0d", VEC_REQ[i], i), int'(VEC[i][23:16]), int'(VEC[i][7:0]));
    end
    chk("R2 func_en after clear", 32'(func_en), 1);

    // R6 suspend entry with detection on
    wr(1, 8'h07);
    bus_susp_det = 1'b1;
    ev_wait();
    chk("R6 suspend entered", 32'(susp_state), 1);
    chk("R6 suspend flag", 32'(irq_flags), 3'b001);
    bus_susp_det = 1'b0;
    settle();
    rd_chk("R6 status bit", 0, 8'h03);

    // R7 resume exit
    bus_resm_det = 1'b1;
    ev_wait();
    chk("R7 suspend left", 32'(susp_state), 0);
    chk("R7 resume flag", 32'(irq_flags), 3'b011);
    bus_resm_det = 1'b0;
    settle();

    // R10 write-one-to-clear
    wr(2, 8'h01);
    rd_chk("R10 clear suspend flag only", 2, 8'h02);
    wr(2, 8'h02);
    rd_chk("R10 clear resume flag", 2, 8'h00);

    // R7 resume while awake raises nothing
    bus_resm_det = 1'b1;
    ev_wait();
    chk("R7 no flag when awake", 32'(irq_flags), 0);
    bus_resm_det = 1'b0;
    settle();

    // R6 detection disabled
    wr(0, 8'h00);
    bus_susp_det = 1'b1;
    ev_wait();
    chk("R6 disabled no suspend", 32'(susp_state), 0);
    chk("R6 disabled no flag", 32'(irq_flags), 0);
    bus_susp_det = 1'b0;
    settle();

    // suspend with only suspend interrupt enabled, then bus reset
    wr(0, 8'h01);
    wr(1, 8'h01);
    bus_susp_det = 1'b1;
    ev_wait();
    bus_susp_det = 1'b0;
    settle();
    chk("R6 suspended before reset", 32'(susp_state), 1);
    bus_rst_det = 1'b1;
    ev_wait();
    chk("R3 strobes high", 32'(strobes()), 5'h1f);
    chk("R7 reset leaves suspend", 32'(susp_state), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R3 strobes one cycle", 32'(strobes()), 0);
    rd_chk("R4 reset flag held", 0, 8'h09);
    rd_chk("R5 enables preset", 1, 8'h07);
    rd_chk("R5 flags after reset", 2, 8'h05);
    chk("R3 no second pulse", 32'(strobes()), 0);
    bus_rst_det = 1'b0;
    settle();
    rd_chk("R4 reset flag cleared", 0, 8'h01);
    wr(2, 8'h07);

    // R8 remote wakeup from suspend
    bus_susp_det = 1'b1;
    ev_wait();
    bus_susp_det = 1'b0;
    settle();
    chk("R8 suspended before wake", 32'(susp_state), 1);
    wr(0, 8'h05);
    chk("R8 wake driven", 32'(wake_drive), 1);
    chk("R8 suspend cleared", 32'(susp_state), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 wake held", 32'(wake_drive), 1);
    wr(0, 8'h01);
    chk("R8 wake released", 32'(wake_drive), 0);

    // R9 self-reset
    wr(0, 8'h08);
    chk("R9 strobes", 32'(strobes()), 5'h1f);
    chk("R9 inhibit restored", 32'(func_en), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 strobes end", 32'(strobes()), 0);
    rd_chk("R9 power reg", 0, 8'h10);
    rd_chk("R9 enable reg", 1, 8'h06);
    rd_chk("R9 flag reg", 2, 8'h00);
    wr(0, 8'h00);
    chk("R2 enable after self-reset", 32'(func_en), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule